// File: doc/BRIEF.md
# I/O Port Glue for an 8-bit Processor Bus

This block sits between an 8-bit processor's I/O bus and a small group of peripherals: two removable memory cards on a shared SPI link, a UART, a five-line joystick and a non-maskable interrupt source. It decodes the low address byte during I/O cycles and turns each bus write into a single data strobe for the addressed peripheral. It holds a chip-select register for the two cards and an interrupt enable bit. During a read of a readable port it drives the bus with that port's data. The bus is modelled synchronously: the active-low I/O request, read and write lines and the address are sampled on the rising clock edge.

A build parameter picks the variant. In the full build all four ports can be read. In the standard build only the SPI data port can be read. Writes are decoded the same way in both builds. The UART and SPI engines are outside the block. Each one receives a valid pulse with a byte and returns its receive byte, plus status for the UART. The transmit valid pulses apply no back-pressure: a pulse lasts exactly one cycle, there is no ready input, and the engine must take the byte in that cycle. The byte stays on the data output until the next decoded write.

Top module: `io_port_glue`

## Requirements
- R1: After reset, both card selects are high, the interrupt enable is 0, both transmit valids are 0 and the data bus is not driven.
- R2: A write to address 0x1F loads the chip-select register. Data bit 0 drives card 0's select and data bit 1 drives card 1's select. Both selects are active low.
- R3: When both chip-select bits are 0, card 0's select is low and card 1's select is forced high. The two selects are never low together.
- R4: Every decoded write gives exactly one strobe. The strobe comes on the LATCH_CYC-th rising edge (default 2) while request and write are both held low, however long the write lasts. Address 0x0F pulses the UART valid and 0x3F pulses the SPI valid, each for one cycle, with the bus byte on the transmit data output. Chip-select and interrupt-enable writes take effect on that same edge.
- R5: Bit 0 of a write to 0x2F sets the interrupt enable. The interrupt request output equals the source input when the enable is 1 and is 0 when it is 0.
- R6: In the full build, reads return these bytes: 0x0F gives the UART receive byte, 0x1F gives {3'b000, joystick[4:0]} with 1 meaning active, 0x2F gives {4'b0000, UART status[3:0]}, and 0x3F gives the SPI receive byte.
- R7: In the standard build only 0x3F can be read. Reads of the other ports leave the bus undriven, while writes to all ports still work as in R2, R4 and R5.
- R8: The bus output enable is 1 only while request and read are both low on a readable address. When the bus is not driven, the data output is 0.
- R9: Writes to addresses other than the four decoded ones give no strobe and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read, active low |
| wr_n | input | 1 | Write, active low |
| addr | input | 8 | Low address byte |
| din | input | 8 | Bus data from the processor |
| dout | output | 8 | Bus data to the processor |
| dout_oe | output | 1 | Drive enable for dout |
| joy | input | 5 | Joystick lines, 1 = active |
| uart_status | input | 4 | UART status nibble |
| uart_rx_data | input | 8 | UART receive byte |
| spi_rx_data | input | 8 | SPI receive byte |
| nmi_src | input | 1 | Interrupt source |
| uart_tx_valid | output | 1 | One-cycle UART transmit strobe |
| spi_tx_valid | output | 1 | One-cycle SPI transmit strobe |
| tx_data | output | 8 | Byte for the strobed engine |
| card_cs_n | output | 2 | Card selects, active low |
| nmi_req | output | 1 | Gated interrupt request |

## Verification
The chip-select register is driven with all four two-bit patterns, so each card on its own, both deselected and the both-zero conflict can be told apart. Writes to each data port use different bytes and different hold lengths. The scoreboard can then tell whether a strobe reached the wrong engine, carried the wrong byte or fired more than once in a long write. Writes to near-miss addresses must produce nothing. The same bus traffic goes to a full-build and a standard-build instance, so read visibility and write activity can be compared between the two variants.

// File: rtl/iopg_pkg.sv
package iopg_pkg;
  localparam int NPORTS = 4;
  localparam int NCARDS = 2;

  typedef enum logic [1:0] {
    PORT_UART = 2'd0,
    PORT_CTRL = 2'd1,
    PORT_STAT = 2'd2,
    PORT_SPI  = 2'd3
  } port_e;

  localparam logic [7:0] PORT_ADDR [NPORTS] = '{8'h0F, 8'h1F, 8'h2F, 8'h3F};

  function automatic logic [NPORTS-1:0] read_mask(input bit full);
    logic [NPORTS-1:0] m;
    m = '0;
    m[PORT_SPI] = 1'b1;
    if (full) m = '1;
    return m;
  endfunction
endpackage

// File: rtl/iopg_addr_decode.sv
module iopg_addr_decode
  import iopg_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0]     addr,
  output logic [NPORTS-1:0] sel
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_match
    assign sel[i] = (addr == PORT_ADDR[i][AW-1:0]);
  end
endmodule

// File: rtl/iopg_write_seq.sv
module iopg_write_seq
  import iopg_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LATCH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic [NPORTS-1:0] sel,
  input  logic [DW-1:0]     din,
  output logic              fire,
  output logic [NPORTS-1:0] stb,
  output logic [DW-1:0]     data_q
);
  localparam int CW = $clog2(LATCH_CYC + 1);

  logic [CW-1:0] cnt;
  logic          wr_act;

  assign wr_act = !iorq_n && !wr_n;
  assign fire   = wr_act && (cnt == CW'(LATCH_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      stb    <= '0;
      data_q <= '0;
    end else begin
      stb <= fire ? sel : '0;
      if (!wr_act)
        cnt <= '0;
      else if (cnt != CW'(LATCH_CYC))
        cnt <= cnt + 1'b1;
      if (fire && (|sel))
        data_q <= din;
    end
  end
endmodule

// File: rtl/iopg_ctrl_regs.sv
module iopg_ctrl_regs
  import iopg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sel_ctrl,
  input  logic              sel_stat,
  input  logic [NCARDS-1:0] din_lo,
  input  logic              nmi_src,
  output logic [NCARDS-1:0] card_cs_n,
  output logic              nmi_req
);
  logic [NCARDS-1:0] cs_q;
  logic              nmi_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      nmi_en <= 1'b0;
    end else if (fire) begin
      if (sel_ctrl) cs_q   <= din_lo;
      if (sel_stat) nmi_en <= din_lo[0];
    end
  end

  // card 0 has priority: card 1 is only selected when card 0 is not
  assign card_cs_n[0] = cs_q[0];
  assign card_cs_n[1] = cs_q[1] | ~cs_q[0];
  assign nmi_req      = nmi_en & nmi_src;
endmodule

// File: rtl/iopg_read_mux.sv
module iopg_read_mux
  import iopg_pkg::*;
#(
  parameter int DW         = 8,
  parameter int JW         = 5,
  parameter int SW         = 4,
  parameter bit FULL_BUILD = 1'b1
) (
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic [NPORTS-1:0] sel,
  input  logic [DW-1:0]     uart_rx_data,
  input  logic [JW-1:0]     joy,
  input  logic [SW-1:0]     uart_status,
  input  logic [DW-1:0]     spi_rx_data,
  output logic [DW-1:0]     dout,
  output logic              dout_oe
);
  localparam logic [NPORTS-1:0] RMASK = read_mask(FULL_BUILD);

  logic [DW-1:0]     src [NPORTS];
  logic [NPORTS-1:0] hit;

  assign src[PORT_SPI] = spi_rx_data;

  if (FULL_BUILD) begin : g_full
    assign src[PORT_UART] = uart_rx_data;
    assign src[PORT_CTRL] = {{(DW-JW){1'b0}}, joy};
    assign src[PORT_STAT] = {{(DW-SW){1'b0}}, uart_status};
  end else begin : g_std
    assign src[PORT_UART] = '0;
    assign src[PORT_CTRL] = '0;
    assign src[PORT_STAT] = '0;
  end

  assign hit     = (!iorq_n && !rd_n) ? (sel & RMASK) : '0;
  assign dout_oe = |hit;

  always_comb begin
    dout = '0;
    for (int i = 0; i < NPORTS; i++)
      if (hit[i]) dout = dout | src[i];
  end
endmodule

// File: rtl/io_port_glue.sv
module io_port_glue
  import iopg_pkg::*;
#(
  parameter bit FULL_BUILD = 1'b1,
  parameter int LATCH_CYC  = 2,
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int JW         = 5,
  parameter int SW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  input  logic [JW-1:0] joy,
  input  logic [SW-1:0] uart_status,
  input  logic [DW-1:0] uart_rx_data,
  input  logic [DW-1:0] spi_rx_data,
  input  logic          nmi_src,
  output logic          uart_tx_valid,
  output logic          spi_tx_valid,
  output logic [DW-1:0] tx_data,
  output logic [1:0]    card_cs_n,
  output logic          nmi_req
);
  logic [NPORTS-1:0] sel;
  logic [NPORTS-1:0] stb;
  logic              fire;

  iopg_addr_decode #(.AW(AW)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  iopg_write_seq #(.DW(DW), .LATCH_CYC(LATCH_CYC)) u_wseq (
    .clk    (clk),
    .rst_n  (rst_n),
    .iorq_n (iorq_n),
    .wr_n   (wr_n),
    .sel    (sel),
    .din    (din),
    .fire   (fire),
    .stb    (stb),
    .data_q (tx_data)
  );

  iopg_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .sel_ctrl  (sel[PORT_CTRL]),
    .sel_stat  (sel[PORT_STAT]),
    .din_lo    (din[NCARDS-1:0]),
    .nmi_src   (nmi_src),
    .card_cs_n (card_cs_n),
    .nmi_req   (nmi_req)
  );

  iopg_read_mux #(.DW(DW), .JW(JW), .SW(SW), .FULL_BUILD(FULL_BUILD)) u_rmux (
    .iorq_n       (iorq_n),
    .rd_n         (rd_n),
    .sel          (sel),
    .uart_rx_data (uart_rx_data),
    .joy          (joy),
    .uart_status  (uart_status),
    .spi_rx_data  (spi_rx_data),
    .dout         (dout),
    .dout_oe      (dout_oe)
  );

  assign uart_tx_valid = stb[PORT_UART];
  assign spi_tx_valid  = stb[PORT_SPI];
endmodule

// File: rtl/io_port_glue_checker.sv
module io_port_glue_checker #(
  parameter bit FULL_BUILD = 1'b1,
  parameter int AW         = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iorq_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [AW-1:0] addr,
  input logic          dout_oe,
  input logic          uart_tx_valid,
  input logic          spi_tx_valid,
  input logic [1:0]    card_cs_n,
  input logic          nmi_src,
  input logic          nmi_req
);
  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    card_cs_n != 2'b00); // R3
  AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!iorq_n && !rd_n)); // R8
  AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({uart_tx_valid, spi_tx_valid})); // R4
  AST_UART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    uart_tx_valid |=> !uart_tx_valid); // R4
  AST_SPI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |=> !spi_tx_valid); // R4
  AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_tx_valid || spi_tx_valid) |-> $past(!iorq_n && !wr_n)); // R4
  AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> nmi_src); // R5
  AST_STD_READ_ONLY_SPI: assert property (@(posedge clk) disable iff (!rst_n)
    (!FULL_BUILD && dout_oe) |-> (addr == AW'(8'h3F))); // R7
endmodule

bind io_port_glue io_port_glue_checker #(.FULL_BUILD(FULL_BUILD), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .iorq_n        (iorq_n),
  .rd_n          (rd_n),
  .wr_n          (wr_n),
  .addr          (addr),
  .dout_oe       (dout_oe),
  .uart_tx_valid (uart_tx_valid),
  .spi_tx_valid  (spi_tx_valid),
  .card_cs_n     (card_cs_n),
  .nmi_src       (nmi_src),
  .nmi_req       (nmi_req)
);

// File: tb/io_port_glue_bench.sv
module io_port_glue_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] addr = 8'h00, din = 8'h00;
  logic [4:0] joy = 5'b10110;
  logic [3:0] uart_status = 4'b1010;
  logic [7:0] uart_rx_data = 8'hC3, spi_rx_data = 8'h5A;
  logic       nmi_src = 1'b1;

  logic [7:0] f_dout, s_dout, f_tx, s_tx;
  logic       f_oe, s_oe, f_uv, s_uv, f_sv, s_sv, f_nmi, s_nmi;
  logic [1:0] f_cs, s_cs;

  int checks = 0, errors = 0;
  int f_strobes = 0, s_strobes = 0;
  bit done = 1'b0;
  logic [9:0] expq [$];

  always #4 clk = ~clk;

  io_port_glue #(.FULL_BUILD(1'b1)) u_io_port_glue (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(f_dout), .dout_oe(f_oe), .joy(joy),
    .uart_status(uart_status), .uart_rx_data(uart_rx_data),
    .spi_rx_data(spi_rx_data), .nmi_src(nmi_src), .uart_tx_valid(f_uv),
    .spi_tx_valid(f_sv), .tx_data(f_tx), .card_cs_n(f_cs), .nmi_req(f_nmi));

  io_port_glue #(.FULL_BUILD(1'b0)) u_io_port_glue_std (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(s_dout), .dout_oe(s_oe), .joy(joy),
    .uart_status(uart_status), .uart_rx_data(uart_rx_data),
    .spi_rx_data(spi_rx_data), .nmi_src(nmi_src), .uart_tx_valid(s_uv),
    .spi_tx_valid(s_sv), .tx_data(s_tx), .card_cs_n(s_cs), .nmi_req(s_nmi));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each strobe of the full-build instance pops one item
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (s_uv || s_sv) s_strobes++;
      if (f_uv || f_sv) begin
        f_strobes++;
        if (expq.size() == 0) begin
          check(1'b0, "R4/R9 unexpected strobe", {22'd0, f_sv, f_uv, f_tx}, 32'd0);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          check({f_sv, f_uv, f_tx} == e, "R4 strobe item", {22'd0, f_sv, f_uv, f_tx}, {22'd0, e});
        end
      end
    end
  end

  // Driver: a write held for 'hold' rising edges; item = {spi, uart, data}
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input int hold);
    if (a == 8'h0F) expq.push_back({2'b01, d});
    if (a == 8'h3F) expq.push_back({2'b10, d});
    @(negedge clk);
    addr = a; din = d; iorq_n = 1'b0; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [7:0] a, input bit iorq,
                          output logic [7:0] fd, output logic fo,
                          output logic [7:0] sd, output logic so);
    @(negedge clk);
    addr = a; iorq_n = !iorq; rd_n = 1'b0;
    #1;
    fd = f_dout; fo = f_oe; sd = s_dout; so = s_oe;
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [7:0] fd, sd;
    logic       fo, so;

    repeat (3) @(negedge clk);
    check(f_cs == 2'b11 && s_cs == 2'b11, "R1 selects high", {f_cs, s_cs}, 4'hF);
    check(!f_nmi && !s_nmi, "R1 nmi off", {f_nmi, s_nmi}, 0);
    check(!f_uv && !f_sv && !f_oe && !s_oe, "R1 idle", {f_uv, f_sv, f_oe, s_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    bus_write(8'h1F, 8'hFE, 3);
    check(f_cs == 2'b10 && s_cs == 2'b10, "R2 card0 only / R7 std write", {f_cs, s_cs}, 4'hA);
    bus_write(8'h1F, 8'hFD, 3);
    check(f_cs == 2'b01, "R2 card1 only", f_cs, 2'b01);
    bus_write(8'h1F, 8'hFC, 3);
    check(f_cs == 2'b10 && s_cs == 2'b10, "R3 card0 wins", {f_cs, s_cs}, 4'hA);
    bus_write(8'h1F, 8'h03, 3);
    check(f_cs == 2'b11, "R2 both off", f_cs, 2'b11);

    bus_write(8'h3F, 8'h55, 3);
    bus_write(8'h0F, 8'hA7, 3);
    bus_write(8'h3F, 8'h81, 7);  // R4: long write, one strobe only
    bus_write(8'h0F, 8'h3C, 2);
    check(expq.size() == 0, "R4 all strobes seen", expq.size(), 0);

    bus_write(8'h2F, 8'h01, 3);
    check(f_nmi && s_nmi, "R5 nmi enabled", {f_nmi, s_nmi}, 3);
    @(negedge clk); nmi_src = 1'b0; #1;
    check(!f_nmi, "R5 follows source", f_nmi, 0);
    nmi_src = 1'b1;
    bus_write(8'h2F, 8'hFE, 3);
    check(!f_nmi && !s_nmi, "R5 nmi disabled", {f_nmi, s_nmi}, 0);

    bus_write(8'h1F, 8'hFE, 3);
    bus_write(8'h1E, 8'h03, 3);
    bus_write(8'h4F, 8'hFD, 3);
    bus_write(8'h3E, 8'h11, 3);
    check(f_cs == 2'b10, "R9 near-miss writes ignored", f_cs, 2'b10);

    bus_read(8'h0F, 1'b1, fd, fo, sd, so);
    check(fo && fd == 8'hC3, "R6 uart rx read", {fo, fd}, 9'h1C3);
    check(!so && sd == 8'h00, "R7 std uart rx hidden", {so, sd}, 0);
    bus_read(8'h1F, 1'b1, fd, fo, sd, so);
    check(fo && fd == 8'h16, "R6 joystick read", {fo, fd}, 9'h116);
    check(!so && sd == 8'h00, "R7 std joystick hidden", {so, sd}, 0);
    bus_read(8'h2F, 1'b1, fd, fo, sd, so);
    check(fo && fd == 8'h0A, "R6 status read", {fo, fd}, 9'h10A);
    check(!so, "R7 std status hidden", so, 0);
    bus_read(8'h3F, 1'b1, fd, fo, sd, so);
    check(fo && fd == 8'h5A, "R6 spi read", {fo, fd}, 9'h15A);
    check(so && sd == 8'h5A, "R7 std spi read", {so, sd}, 9'h15A);
    bus_read(8'h3F, 1'b0, fd, fo, sd, so);
    check(!fo && fd == 8'h00 && !so, "R8 no request no drive", {fo, fd}, 0);
    bus_read(8'h55, 1'b1, fd, fo, sd, so);
    check(!fo && fd == 8'h00, "R8 unmapped read", {fo, fd}, 0);

    check(s_strobes == f_strobes && f_strobes == 4, "R7 std writes strobe", s_strobes, f_strobes);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule